// File: doc/BRIEF.md
# Vector Context Prefix Header Parser

This block decodes the leading 16-bit parcel of a variable-length instruction that gives vector context to a group of scalar opcodes. It also reads a window of the parcels that follow. From the header it decides whether the parcel is such a prefix and how long the whole instruction is. It then finds where the optional vector-length block, the register-context entries, the predicate-context entries and the embedded opcode area start. It also reports when the context sections leave no room for any opcode.

Each context entry is unpacked into its own slot. A slot carries a valid flag, its payload, its parcel position and a half-parcel flag. In the compact byte format, a predicate slot also gets an implicit register number. Fetch alignment and the meaning of the embedded opcodes and entry payloads are outside this block. The result is registered and appears one cycle after the input strobe.

Top module: `vbp_parser`

## Requirements
- R1: The header is accepted (`out_hdr_ok`=1) only when bits 6:0 are all ones and the length field in bits 14:12 is not 7. When it is not accepted, every output except `out_valid` is zero.
- R2: For an accepted header with length field n, `out_len_parcels` is 5+n and `out_len_bits` is 80+16n.
- R3: `out_vl_present` equals header bit 15. The register section starts at parcel 1 when the vector-length block is absent and at parcel 2 when it is present. Offsets are counted in parcels, and the prefix is parcel 0.
- R4: Let R be the value of bits 9:8 and P the value of bits 11:10. Then `out_pred_off` = `out_reg_off` + R and `out_ops_off` = `out_pred_off` + P, in both entry formats. In the compact format each section holds 2R or 2P byte entries, so it still spans R or P whole parcels.
- R5: When bit 7 is 1 (wide format), slot k of a section is valid for k below the section count. Its payload is the whole parcel at section start + k, and its half flag is 0. Window element i (`in_win[i]`) holds parcel i+1.
- R6: When bit 7 is 0 (compact format), slot k exists for k below twice the count and lies in parcel section start + k/2. An even k takes bits 7:0 of that parcel and an odd k takes bits 15:8. The half flag equals k odd, and the payload is the byte zero-extended. `out_compact` is the inverse of bit 7 for an accepted header.
- R7: A compact slot whose byte is 0x00 has its valid flag cleared, while its position and half flag are still reported.
- R8: A compact predicate slot k within the count carries register number 9+k. Otherwise the number is 0, and this includes every slot in the wide format.
- R9: `out_room_err` is 1 exactly when `out_ops_off` is greater than or equal to `out_len_parcels`.
- R10: Outputs change only on the cycle after `in_valid` is high. `out_valid` is high on that cycle alone, and decoded fields hold while `in_valid` is low. Synchronous reset clears all outputs. Slots beyond a section's count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header and window present this cycle |
| in_hdr | input | 16 | First parcel of the instruction |
| in_win | input | 7x16 | Following parcels, element i is parcel i+1 |
| out_valid | output | 1 | Result registered this cycle |
| out_hdr_ok | output | 1 | Header recognised |
| out_compact | output | 1 | Byte-wide entry format in use |
| out_vl_present | output | 1 | Vector-length block present at parcel 1 |
| out_len_bits | output | 8 | Total instruction length in bits |
| out_len_parcels | output | 4 | Total instruction length in parcels |
| out_reg_off | output | 4 | Parcel offset of register entries |
| out_pred_off | output | 4 | Parcel offset of predicate entries |
| out_ops_off | output | 4 | Parcel offset of the opcode area |
| out_room_err | output | 1 | No opcode space left |
| out_reg_vld | output | 6 | Register slot valid flags |
| out_reg_data | output | 6x16 | Register slot payloads |
| out_reg_pos | output | 6x4 | Register slot parcel positions |
| out_reg_half | output | 6 | Register slot in upper byte |
| out_pred_vld | output | 6 | Predicate slot valid flags |
| out_pred_data | output | 6x16 | Predicate slot payloads |
| out_pred_pos | output | 6x4 | Predicate slot parcel positions |
| out_pred_half | output | 6 | Predicate slot in upper byte |
| out_pred_num | output | 6x5 | Implicit predicate register numbers |

## Verification
The hardest cases to reach are the ones where the compact format, padding and section placement meet. A zero byte has to fall in the upper half of a parcel, inside the last predicate section, after a vector-length block, in a header whose length is too short for opcodes. To reach them, the stimulus sweeps every combination of header bits 15:7 with the prefix pattern held valid. It does this over two windows: one with every byte nonzero, and one with zero bytes in both halves of chosen parcels. A second sweep walks every invalid value of bits 6:0.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
  // parcel and header field geometry (fixed by the prefix format)
  localparam int PW        = 16;
  localparam int HB        = PW / 2;
  localparam int CNT_W     = 2;
  localparam int LEN_W     = 3;
  localparam int OPC_W     = 7;
  localparam int BASE_PARC = 5;
  localparam int MAX_WIDE  = (1 << CNT_W) - 1;
  localparam int MAX_ENT   = 2 * MAX_WIDE;
  localparam int WIN_MIN   = 1 + 2 * MAX_WIDE;
  localparam int MAX_LEN   = BASE_PARC + (1 << LEN_W) - 2;
  localparam int OFF_W     = $clog2(MAX_LEN + 1);
  localparam int LENB_W    = OFF_W + $clog2(PW);
  localparam int NUM_W     = 5;
endpackage

// File: rtl/vbp_hdr_dec.sv
module vbp_hdr_dec
  import vbp_pkg::*;
(
  input  logic [PW-1:0]     hdr,
  output logic              ok,
  output logic              compact,
  output logic              vl,
  output logic [OFF_W-1:0]  len_parc,
  output logic [LENB_W-1:0] len_bits,
  output logic [OFF_W-1:0]  reg_off,
  output logic [OFF_W-1:0]  pred_off,
  output logic [OFF_W-1:0]  ops_off,
  output logic              room_err,
  output logic [CNT_W-1:0]  rcnt,
  output logic [CNT_W-1:0]  pcnt
);
  logic [LEN_W-1:0] nlen;

  always_comb begin
    nlen     = hdr[14:12];
    ok       = (&hdr[OPC_W-1:0]) && (nlen != {LEN_W{1'b1}});
    compact  = ~hdr[7];
    vl       = hdr[15];
    rcnt     = hdr[9:8];
    pcnt     = hdr[11:10];
    len_parc = OFF_W'(BASE_PARC) + OFF_W'(nlen);
    len_bits = LENB_W'(len_parc) << $clog2(PW);
    reg_off  = OFF_W'(1) + OFF_W'(vl);
    pred_off = reg_off + OFF_W'(rcnt);
    ops_off  = pred_off + OFF_W'(pcnt);
    room_err = ops_off >= len_parc;
  end
endmodule

// File: rtl/vbp_ent_unpack.sv
module vbp_ent_unpack
  import vbp_pkg::*;
#(
  parameter int WIN = WIN_MIN
)(
  input  logic [WIN-1:0][PW-1:0]     win,
  input  logic [OFF_W-1:0]           base,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       compact,
  input  logic                       en,
  output logic [MAX_ENT-1:0]         vld,
  output logic [MAX_ENT-1:0][PW-1:0] data,
  output logic [MAX_ENT-1:0][OFF_W-1:0] pos,
  output logic [MAX_ENT-1:0]         half
);
  logic [OFF_W-1:0] lim;
  assign lim = compact ? (OFF_W'(cnt) << 1) : OFF_W'(cnt);

  for (genvar k = 0; k < MAX_ENT; k++) begin : g_slot
    localparam logic [OFF_W-1:0] K_FULL = OFF_W'(k);
    localparam logic [OFF_W-1:0] K_HALF = OFF_W'(k / 2);
    localparam bit               ODD    = (k % 2) == 1;

    logic             in_rng;
    logic [OFF_W-1:0] pidx;
    logic [PW-1:0]    par;
    logic [HB-1:0]    byt;

    assign in_rng = en && (K_FULL < lim);
    assign pidx   = base + (compact ? K_HALF : K_FULL);

    always_comb begin
      par = '0;
      for (int w = 0; w < WIN; w++)
        if (pidx == OFF_W'(w + 1)) par = win[w];
    end

    assign byt     = ODD ? par[PW-1:HB] : par[HB-1:0];
    assign vld[k]  = in_rng && (!compact || (byt != '0));
    assign data[k] = !in_rng ? '0 : (compact ? PW'(byt) : par);
    assign pos[k]  = in_rng ? pidx : '0;
    assign half[k] = in_rng && compact && ODD;
  end
endmodule

// File: rtl/vbp_parser.sv
module vbp_parser
  import vbp_pkg::*;
#(
  parameter int WIN       = WIN_MIN,
  parameter int IMPL_BASE = 9
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [PW-1:0]                 in_hdr,
  input  logic [WIN-1:0][PW-1:0]        in_win,
  output logic                          out_valid,
  output logic                          out_hdr_ok,
  output logic                          out_compact,
  output logic                          out_vl_present,
  output logic [LENB_W-1:0]             out_len_bits,
  output logic [OFF_W-1:0]              out_len_parcels,
  output logic [OFF_W-1:0]              out_reg_off,
  output logic [OFF_W-1:0]              out_pred_off,
  output logic [OFF_W-1:0]              out_ops_off,
  output logic                          out_room_err,
  output logic [MAX_ENT-1:0]            out_reg_vld,
  output logic [MAX_ENT-1:0][PW-1:0]    out_reg_data,
  output logic [MAX_ENT-1:0][OFF_W-1:0] out_reg_pos,
  output logic [MAX_ENT-1:0]            out_reg_half,
  output logic [MAX_ENT-1:0]            out_pred_vld,
  output logic [MAX_ENT-1:0][PW-1:0]    out_pred_data,
  output logic [MAX_ENT-1:0][OFF_W-1:0] out_pred_pos,
  output logic [MAX_ENT-1:0]            out_pred_half,
  output logic [MAX_ENT-1:0][NUM_W-1:0] out_pred_num
);
  logic              ok, compact, vl, room_err;
  logic [OFF_W-1:0]  len_parc, reg_off, pred_off, ops_off;
  logic [LENB_W-1:0] len_bits;
  logic [CNT_W-1:0]  rcnt, pcnt;

  vbp_hdr_dec u_dec (
    .hdr(in_hdr), .ok(ok), .compact(compact), .vl(vl),
    .len_parc(len_parc), .len_bits(len_bits), .reg_off(reg_off),
    .pred_off(pred_off), .ops_off(ops_off), .room_err(room_err),
    .rcnt(rcnt), .pcnt(pcnt)
  );

  logic [MAX_ENT-1:0]            r_vld, p_vld, r_half, p_half;
  logic [MAX_ENT-1:0][PW-1:0]    r_data, p_data;
  logic [MAX_ENT-1:0][OFF_W-1:0] r_pos, p_pos;
  logic [MAX_ENT-1:0][NUM_W-1:0] p_num;

  vbp_ent_unpack #(.WIN(WIN)) u_reg (
    .win(in_win), .base(reg_off), .cnt(rcnt), .compact(compact), .en(ok),
    .vld(r_vld), .data(r_data), .pos(r_pos), .half(r_half)
  );

  vbp_ent_unpack #(.WIN(WIN)) u_pred (
    .win(in_win), .base(pred_off), .cnt(pcnt), .compact(compact), .en(ok),
    .vld(p_vld), .data(p_data), .pos(p_pos), .half(p_half)
  );

  logic [OFF_W-1:0] plim;
  assign plim = OFF_W'(pcnt) << 1;

  for (genvar k = 0; k < MAX_ENT; k++) begin : g_num
    assign p_num[k] = (ok && compact && (OFF_W'(k) < plim)) ?
                      NUM_W'(IMPL_BASE + k) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_hdr_ok      <= 1'b0;
      out_compact     <= 1'b0;
      out_vl_present  <= 1'b0;
      out_len_bits    <= '0;
      out_len_parcels <= '0;
      out_reg_off     <= '0;
      out_pred_off    <= '0;
      out_ops_off     <= '0;
      out_room_err    <= 1'b0;
      out_reg_vld     <= '0;
      out_reg_data    <= '0;
      out_reg_pos     <= '0;
      out_reg_half    <= '0;
      out_pred_vld    <= '0;
      out_pred_data   <= '0;
      out_pred_pos    <= '0;
      out_pred_half   <= '0;
      out_pred_num    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hdr_ok      <= ok;
        out_compact     <= ok & compact;
        out_vl_present  <= ok & vl;
        out_len_bits    <= ok ? len_bits : '0;
        out_len_parcels <= ok ? len_parc : '0;
        out_reg_off     <= ok ? reg_off  : '0;
        out_pred_off    <= ok ? pred_off : '0;
        out_ops_off     <= ok ? ops_off  : '0;
        out_room_err    <= ok & room_err;
        out_reg_vld     <= r_vld;
        out_reg_data    <= r_data;
        out_reg_pos     <= r_pos;
        out_reg_half    <= r_half;
        out_pred_vld    <= p_vld;
        out_pred_data   <= p_data;
        out_pred_pos    <= p_pos;
        out_pred_half   <= p_half;
        out_pred_num    <= p_num;
      end
    end
  end
endmodule

// File: rtl/vbp_parser_chk.sv
module vbp_parser_chk
  import vbp_pkg::*;
(
  input logic                          clk,
  input logic                          rst,
  input logic                          in_valid,
  input logic [PW-1:0]                 in_hdr,
  input logic                          out_valid,
  input logic                          out_hdr_ok,
  input logic                          out_compact,
  input logic [LENB_W-1:0]             out_len_bits,
  input logic [OFF_W-1:0]              out_len_parcels,
  input logic [OFF_W-1:0]              out_reg_off,
  input logic [OFF_W-1:0]              out_pred_off,
  input logic [OFF_W-1:0]              out_ops_off,
  input logic                          out_room_err,
  input logic [MAX_ENT-1:0]            out_reg_vld,
  input logic [MAX_ENT-1:0]            out_pred_vld,
  input logic [MAX_ENT-1:0]            out_reg_half,
  input logic [MAX_ENT-1:0]            out_pred_half,
  input logic [MAX_ENT-1:0][NUM_W-1:0] out_pred_num
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_recognise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_hdr_ok == ((&$past(in_hdr[OPC_W-1:0])) &&
                                ($past(in_hdr[14:12]) != 3'b111)));

  a_r1_quiet_reject: assert property (@(posedge clk) disable iff (rst)
    !out_hdr_ok |-> (out_reg_vld == '0) && (out_pred_vld == '0) &&
                    (out_len_bits == '0) && !out_room_err);

  a_r2_len_units: assert property (@(posedge clk) disable iff (rst)
    out_hdr_ok |-> out_len_bits == (LENB_W'(out_len_parcels) << $clog2(PW)));

  a_r4_section_order: assert property (@(posedge clk) disable iff (rst)
    out_hdr_ok |-> (out_reg_off <= out_pred_off) && (out_pred_off <= out_ops_off));

  a_r9_room_ok: assert property (@(posedge clk) disable iff (rst)
    (out_hdr_ok && !out_room_err) |-> out_ops_off < out_len_parcels);

  a_r8_wide_no_half: assert property (@(posedge clk) disable iff (rst)
    !out_compact |-> ($countones(out_reg_half) == 0) &&
                     ($countones(out_pred_half) == 0) && (out_pred_num == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_len_bits) && $stable(out_ops_off) && !out_valid);
endmodule

bind vbp_parser vbp_parser_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr),
  .out_valid(out_valid), .out_hdr_ok(out_hdr_ok), .out_compact(out_compact),
  .out_len_bits(out_len_bits), .out_len_parcels(out_len_parcels),
  .out_reg_off(out_reg_off), .out_pred_off(out_pred_off),
  .out_ops_off(out_ops_off), .out_room_err(out_room_err),
  .out_reg_vld(out_reg_vld), .out_pred_vld(out_pred_vld),
  .out_reg_half(out_reg_half), .out_pred_half(out_pred_half),
  .out_pred_num(out_pred_num)
);

// File: tb/vbp_parser_bench.sv
`timescale 1ns/1ps
module vbp_parser_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             in_valid = 1'b0;
  logic [15:0]      in_hdr = '0;
  logic [6:0][15:0] in_win = '0;
  logic             out_valid, out_hdr_ok, out_compact, out_vl_present, out_room_err;
  logic [7:0]       out_len_bits;
  logic [3:0]       out_len_parcels, out_reg_off, out_pred_off, out_ops_off;
  logic [5:0]       out_reg_vld, out_reg_half, out_pred_vld, out_pred_half;
  logic [5:0][15:0] out_reg_data, out_pred_data;
  logic [5:0][3:0]  out_reg_pos, out_pred_pos;
  logic [5:0][4:0]  out_pred_num;

  vbp_parser u_vbp_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr), .in_win(in_win),
    .out_valid(out_valid), .out_hdr_ok(out_hdr_ok), .out_compact(out_compact),
    .out_vl_present(out_vl_present), .out_len_bits(out_len_bits),
    .out_len_parcels(out_len_parcels), .out_reg_off(out_reg_off),
    .out_pred_off(out_pred_off), .out_ops_off(out_ops_off),
    .out_room_err(out_room_err), .out_reg_vld(out_reg_vld),
    .out_reg_data(out_reg_data), .out_reg_pos(out_reg_pos),
    .out_reg_half(out_reg_half), .out_pred_vld(out_pred_vld),
    .out_pred_data(out_pred_data), .out_pred_pos(out_pred_pos),
    .out_pred_half(out_pred_half), .out_pred_num(out_pred_num)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s hdr=%04h actual=%0d expected=%0d", req, in_hdr, act, exp);
    end
  endtask

  function automatic logic [6:0][15:0] mk_win(input int pat);
    logic [6:0][15:0] w;
    for (int i = 0; i < 7; i++) begin
      if (pat == 0) w[i] = {8'(8'hA0 + i), 8'(8'h50 + i)};
      else w[i] = {((i % 2) == 1) ? 8'h00 : 8'(8'hC0 + i),
                   (i == 2) ? 8'h00 : 8'(8'h30 + i)};
    end
    return w;
  endfunction

  // expected slot contents computed from R5..R8, R10
  task automatic chk_sect(input bit is_pred, input bit ok, input bit comp,
                          input int base, input int cnt);
    for (int k = 0; k < 6; k++) begin
      int lim, p, par, byt, e_vld, e_data, e_pos, e_half, e_num;
      lim = comp ? 2 * cnt : cnt;
      e_vld = 0; e_data = 0; e_pos = 0; e_half = 0; e_num = 0;
      if (ok && k < lim) begin
        p   = comp ? base + k / 2 : base + k;
        par = (p >= 1 && p <= 7) ? int'(in_win[p-1]) : 0;
        byt = (k % 2 == 1) ? (par >> 8) & 255 : par & 255;
        e_pos  = p;
        e_half = (comp && k % 2 == 1) ? 1 : 0;
        e_data = comp ? byt : par;
        e_vld  = comp ? (byt != 0) : 1;
        e_num  = (is_pred && comp) ? 9 + k : 0;
      end
      if (is_pred) begin
        chk(comp ? "R7 pred vld" : "R5 pred vld", int'(out_pred_vld[k]), e_vld);
        chk(comp ? "R6 pred data" : "R5 pred data", int'(out_pred_data[k]), e_data);
        chk(comp ? "R6 pred pos" : "R5 pred pos", int'(out_pred_pos[k]), e_pos);
        chk("R6 pred half", int'(out_pred_half[k]), e_half);
        chk("R8 pred num", int'(out_pred_num[k]), e_num);
      end else begin
        chk(comp ? "R7 reg vld" : "R5 reg vld", int'(out_reg_vld[k]), e_vld);
        chk(comp ? "R6 reg data" : "R5 reg data", int'(out_reg_data[k]), e_data);
        chk(comp ? "R6 reg pos" : "R5 reg pos", int'(out_reg_pos[k]), e_pos);
        chk("R6 reg half", int'(out_reg_half[k]), e_half);
      end
    end
  endtask

  task automatic run_vec(input logic [15:0] h, input int pat);
    bit ok, comp;
    int n, vl, roff, poff, ooff, lenp;
    @(negedge clk);
    in_hdr = h; in_win = mk_win(pat); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ok   = (h[6:0] == 7'h7F) && (h[14:12] != 3'b111);
    comp = ok && !h[7];
    n    = int'(h[14:12]);
    vl   = ok ? int'(h[15]) : 0;
    lenp = ok ? 5 + n : 0;
    roff = ok ? 1 + vl : 0;
    poff = ok ? roff + int'(h[9:8]) : 0;
    ooff = ok ? poff + int'(h[11:10]) : 0;
    chk("R10 valid", int'(out_valid), 1);
    chk("R1 ok", int'(out_hdr_ok), int'(ok));
    chk("R2 len bits", int'(out_len_bits), ok ? 80 + 16 * n : 0);
    chk("R2 len parcels", int'(out_len_parcels), lenp);
    chk("R3 vl", int'(out_vl_present), vl);
    chk("R3 reg off", int'(out_reg_off), roff);
    chk("R4 pred off", int'(out_pred_off), poff);
    chk("R4 ops off", int'(out_ops_off), ooff);
    chk("R9 room err", int'(out_room_err), (ok && ooff >= lenp) ? 1 : 0);
    chk("R6 compact", int'(out_compact), int'(comp));
    chk_sect(1'b0, ok, comp, roff, int'(h[9:8]));
    chk_sect(1'b1, ok, comp, poff, int'(h[11:10]));
    // hold: change inputs without strobe, outputs must stay
    in_hdr = ~h; in_win = mk_win(1 - pat);
    @(negedge clk);
    chk("R10 no strobe", int'(out_valid), 0);
    chk("R10 hold len", int'(out_len_bits), ok ? 80 + 16 * n : 0);
    chk("R10 hold ops", int'(out_ops_off), ooff);
    in_hdr = h; in_win = mk_win(pat);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset valid", int'(out_valid), 0);
    chk("R10 reset ok", int'(out_hdr_ok), 0);
    chk("R10 reset len", int'(out_len_bits), 0);
    chk("R10 reset slots", int'(out_reg_vld | out_pred_vld), 0);
    for (int pat = 0; pat < 2; pat++)
      for (int hi = 0; hi < 512; hi++)
        run_vec({9'(hi), 7'h7F}, pat);
    for (int lo = 0; lo < 127; lo++)
      run_vec({9'h1A5, 7'(lo)}, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule